// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is a memory-mapped SPI master that exchanges exactly one byte per command and has no FIFO. Software sets up a mode byte, a clock divisor and a transmit byte over a simple byte-addressed register bus. It then writes the start bit. The block clocks eight bits out on `mosi` while it clocks eight bits in from `miso`. It then places the received byte in a data register and raises a ready flag, which also serves as the interrupt.

The mode byte selects the idle level of SCK, the edge on which data is sampled, and whether the least significant bit goes first. It also carries a port enable and an internal loopback, in which the outgoing bit is fed straight back into the receiver. SCK runs at the bus clock divided by four times (divisor + 1). Every further byte needs a fresh start command, and each byte produces its own ready event.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0, `sck`, `mosi` and `irq` are low, and status reads 0.
- R2: The bus register offsets are as follows. Mode is at 0, with only bits 4..0 kept. Transmit data is at 2 and the divisor is at 6; both read back as written. Receive data is at 1 and status is at 4. Control (3) and the reserved byte (5) read 0.
- R3: With the port enabled, writing a byte with bit 0 set to offset 3 starts a transfer and sets status busy (value 0x02). A start written while a transfer is already running is ignored and does not change its timing.
- R4: Mode bit 0x02 sets the SCK idle level: 0 idles low and 1 idles high. SCK sits at that level whenever no transfer runs.
- R5: Mode bit 0x10 selects the sampling edge. When it is 1, both sides sample on the leading SCK edge and data changes on the trailing edge. When it is 0, data changes on the leading edge and is sampled on the trailing edge.
- R6: Mode bit 0x04 selects the bit order: 0 puts the most significant bit first on the wire and 1 puts the least significant bit first. The same order applies to both directions.
- R7: A transfer produces exactly 8 SCK pulses. Leading edges are spaced 4×(divisor+1) bus clocks apart, for divisor values 0 to 255.
- R8: With mode bit 0x01 set, the received byte equals the transmitted byte and `miso` has no effect.
- R9: The ready flag (status 0x01) and `irq` rise 16×2×(divisor+1)+1 cycles after the start write. Busy clears one cycle after that.
- R10: Reading offset 1 returns the received byte, and on the next clock it clears ready and `irq`.
- R11: While mode bit 0x08 (enable) is 0, SCK holds its idle level, `mosi` is low, and start writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on receive data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt, equal to the receive-ready flag |

## Verification
The bench attaches a behavioural slave that classifies each SCK transition as leading or trailing from the configured idle level, so a swapped sampling edge shows up as a shifted byte on both sides. Reversed bit order is caught because the bench compares random bytes against wire-order expectations. A wrong divisor formula is caught by timing every leading edge, including a directed run at divisor 255. The bench checks the exact cycle of ready and of busy clearing, so an off-by-one in the completion pipeline fails. It also issues a second start mid-transfer, runs a loopback with a noisy `miso`, and issues a start while disabled; each of these must leave the outcome unchanged.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int CNT_W = 9;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(6);

  logic [7:0]       mode_q, txd_q, rxd_q, div_q, tx_sh, rx_sh;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       edge_q;
  logic             busy_q, rdy_q, fin_q, tail_q, sck_int;

  function automatic logic [7:0] flip(input logic [7:0] v);
    for (int i = 0; i < 8; i++) flip[i] = v[7-i];
  endfunction

  wire en       = mode_q[3];
  wire smp_lead = mode_q[4];
  wire lsb      = mode_q[2];
  wire cpol     = mode_q[1];
  wire loop_en  = mode_q[0];

  wire [CNT_W-1:0] half_m1 = {div_q, 1'b1};
  wire leading   = ~edge_q[0];
  wire shin      = loop_en ? tx_sh[7] : miso;
  wire do_sample = smp_lead ? leading : ~leading;
  wire do_shift  = smp_lead ? ~leading : (leading && edge_q != 4'd0);
  wire start     = bus_wr && bus_addr == A_CTL && bus_wdata[0] && en && !busy_q;
  wire rd_rx     = bus_rd && bus_addr == A_RXD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; txd_q <= '0; rxd_q <= '0; div_q <= '0;
      tx_sh <= '0; rx_sh <= '0; cnt_q <= '0; edge_q <= '0;
      busy_q <= 1'b0; rdy_q <= 1'b0; fin_q <= 1'b0; tail_q <= 1'b0;
      sck_int <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_MODE:  mode_q <= {3'b000, bus_wdata[4:0]};
          A_TXD:   txd_q  <= bus_wdata;
          A_DIV:   div_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (rd_rx) rdy_q <= 1'b0;
      if (!en) begin
        busy_q <= 1'b0; fin_q <= 1'b0; tail_q <= 1'b0; sck_int <= 1'b0;
      end else if (start) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        edge_q  <= '0;
        sck_int <= 1'b0;
        tx_sh   <= lsb ? flip(txd_q) : txd_q;
        rx_sh   <= '0;
      end else if (busy_q) begin
        if (tail_q) begin
          busy_q <= 1'b0;
          tail_q <= 1'b0;
        end else if (fin_q) begin
          rxd_q  <= lsb ? flip(rx_sh) : rx_sh;
          rdy_q  <= 1'b1;
          fin_q  <= 1'b0;
          tail_q <= 1'b1;
        end else if (cnt_q == half_m1) begin
          cnt_q   <= '0;
          sck_int <= ~sck_int;
          edge_q  <= edge_q + 4'd1;
          if (do_sample) rx_sh <= {rx_sh[6:0], shin};
          if (do_shift)  tx_sh <= {tx_sh[6:0], 1'b0};
          if (edge_q == 4'd15) fin_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sck  = en ? (cpol ^ sck_int) : cpol;
  assign mosi = en & busy_q & tx_sh[7];
  assign irq  = rdy_q;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_RXD:   bus_rdata = rxd_q;
      A_TXD:   bus_rdata = txd_q;
      A_STAT:  bus_rdata = {6'b0, busy_q, rdy_q};
      A_DIV:   bus_rdata = div_q;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module spi_byte_master_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        mode_q,
  input logic              busy_q,
  input logic              rdy_q,
  input logic              fin_q,
  input logic              sck
);
  // R9
  busy_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdy_q) && mode_q[3]) |=> !busy_q);
  // R3
  launch_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[0] && mode_q[3]));
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == mode_q[1]));
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[3] |=> !busy_q);
  // R7
  sck_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && $stable(mode_q)) |-> $past(busy_q));
  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1) && !(fin_q && busy_q && mode_q[3])) |=> !rdy_q);
endmodule

bind spi_byte_master spi_byte_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mode_q(mode_q),
  .busy_q(busy_q), .rdy_q(rdy_q), .fin_q(fin_q), .sck(sck)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck, mosi, miso, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  // slave model state
  logic       cfg_cpol = 0, cfg_lead = 0, slv_arm = 0, prev_sck = 0;
  logic [7:0] slv_tx = '0, slv_rx = '0;
  int         slv_idx = 0, lead_cnt = 0, per_bad = 0, exp_per = 20;
  time        last_t = 0;

  always @(sck, slv_arm, slv_tx) begin
    if (!slv_arm) begin
      slv_idx = 0; lead_cnt = 0; per_bad = 0; slv_rx = '0;
      prev_sck = sck; miso = slv_tx[7];
    end else begin
      #1;
      if (sck !== prev_sck) begin
        prev_sck = sck;
        if (sck != cfg_cpol) begin
          lead_cnt++;
          if (lead_cnt > 1 && ($time - last_t) != time'(exp_per)) per_bad++;
          last_t = $time;
          if (cfg_lead) slv_rx = {slv_rx[6:0], mosi};
          else if (slv_idx < 8) miso = slv_tx[7-slv_idx];
        end else begin
          if (cfg_lead) begin
            slv_idx++;
            if (slv_idx < 8) miso = slv_tx[7-slv_idx];
          end else begin
            slv_rx = {slv_rx[6:0], mosi};
            slv_idx++;
          end
        end
      end
    end
  end

  function automatic logic [7:0] mirror(input logic [7:0] v);
    for (int i = 0; i < 8; i++) mirror[i] = v[7-i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic xfer(input logic lead, input logic cpol, input logic lsb,
                      input logic lp, input logic [7:0] dv, input logic [7:0] tx,
                      input logic [7:0] stx, input bit dbl);
    logic [7:0] v;
    int half;
    half = 2 * (int'(dv) + 1);
    wr(3'd6, dv);
    wr(3'd0, {3'b000, lead, 1'b1, lsb, cpol, lp});
    wr(3'd2, tx);
    cfg_lead = lead; cfg_cpol = cpol; exp_per = 20 * (int'(dv) + 1);
    slv_tx = stx;
    @(negedge clk);
    slv_arm = 1'b1;
    chk("R4 idle sck", sck, cpol);
    wr(3'd3, 8'h01);
    peek(3'd4, v); chk("R3 busy set", v, 8'h02);
    if (dbl) begin
      wr(3'd3, 8'h01);
      repeat (16*half - 1) @(posedge clk);
    end else begin
      repeat (16*half) @(posedge clk);
    end
    @(negedge clk);
    peek(3'd4, v); chk("R9 not ready yet", v, 8'h02);
    @(posedge clk); @(negedge clk);
    peek(3'd4, v); chk("R9 ready with busy", v, 8'h03);
    chk("R9 irq", irq, 1'b1);
    @(posedge clk); @(negedge clk);
    peek(3'd4, v); chk("R9 busy cleared", v, 8'h01);
    chk("R4 idle after", sck, cpol);
    chk("R7 pulses", lead_cnt, 8);
    chk("R7 period", per_bad, 0);
    chk("R5 R6 slave got", slv_rx, lsb ? mirror(tx) : tx);
    rd(3'd1, v);
    if (lp) chk("R8 loopback rx", v, tx);
    else    chk("R5 R6 master rx", v, lsb ? mirror(stx) : stx);
    peek(3'd4, v); chk("R10 ready cleared", v, 8'h00);
    chk("R10 irq cleared", irq, 1'b0);
    slv_arm = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v); chk("R1 reg reset", v, 8'h00);
    end
    chk("R1 sck", sck, 1'b0);
    chk("R1 mosi", mosi, 1'b0);
    chk("R1 irq", irq, 1'b0);
    // R2
    wr(3'd0, 8'hF6); peek(3'd0, v); chk("R2 mode readback", v, 8'h16);
    wr(3'd2, 8'hA5); peek(3'd2, v); chk("R2 txd readback", v, 8'hA5);
    wr(3'd6, 8'h3C); peek(3'd6, v); chk("R2 div readback", v, 8'h3C);
    wr(3'd5, 8'hFF); peek(3'd5, v); chk("R2 reserved", v, 8'h00);
    peek(3'd3, v); chk("R2 control reads 0", v, 8'h00);
    // R11: disabled, cpol high, start ignored
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h01);
    repeat (4) @(posedge clk); @(negedge clk);
    peek(3'd4, v); chk("R11 start ignored", v, 8'h00);
    chk("R11 sck idle", sck, 1'b1);
    chk("R11 mosi low", mosi, 1'b0);
    // directed: all four clock modes, both orders
    xfer(1, 0, 0, 0, 8'd0, 8'hB4, 8'h5A, 0);
    xfer(0, 0, 0, 0, 8'd1, 8'hC3, 8'h96, 0);
    xfer(1, 1, 1, 0, 8'd2, 8'h81, 8'h17, 0);
    xfer(0, 1, 1, 0, 8'd0, 8'h3E, 8'hE9, 0);
    // R3 second start mid-transfer ignored
    xfer(1, 0, 0, 0, 8'd3, 8'h69, 8'hF0, 1);
    // R8 loopback with opposing slave data
    xfer(0, 1, 0, 1, 8'd1, 8'h2D, ~8'h2D, 0);
    // R7 largest divisor
    xfer(1, 0, 1, 0, 8'd255, 8'h4B, 8'hD2, 0);
    // random mix
    for (int i = 0; i < 40; i++) begin
      xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 5 == 0),
           8'($urandom % 6), 8'($urandom), 8'($urandom), 1'($urandom % 7 == 0));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule